// File: doc/BRIEF.md
# Picture Memory Bank Address Mapper

This block turns the upper address lines of the picture processor into a banked
video memory address. Eight bank registers and one banking-style control byte
come in from register storage elsewhere. The block has no clock and no state.
It reads PPU address lines A13..A10 and forms the CHR memory lines A17..A10
from them. It also produces a select that routes name-table fetches to the
console's internal name-table RAM, together with that RAM's A10 line.

The control byte is packed as follows:

- bits 1:0 hold the banking mode (0..3);
- bits 3:2 hold the mirroring field;
- bit 4 picks the name-table source (1 = CHR memory, 0 = internal RAM);
- bit 5 picks the A10 rule;
- bits 7:6 play no part in this block.

Bank register k sits at bits `k*BANK_W +: BANK_W` of the flat bank bus.

The block has no stream interface, so there is no valid/ready handshake and no
back-pressure. Every output settles within the same cycle as the inputs that
drive it. In the requirements, "slot" means PPU A12..A10 during a pattern fetch
(A13 = 0), and "q" means {A11, A10} during a name-table fetch (A13 = 1).

Top module: `chr_bank_mapper`

## Requirements
- R1: In mode 0, a pattern fetch outputs bank register `slot` unchanged.
- R2: In mode 1, a pattern fetch uses register A12..A11 (0..3). Output bits 7:1 are that register's bits 7:1.
- R3: In modes 2 and 3, a pattern fetch with A12 = 0 outputs register `slot` (0..3). With A12 = 1 it uses register 4 + A11, and output bits 7:1 are that register's bits 7:1.
- R4: On every 2 KiB pattern slice (R2, and R3 with A12 = 1), output bit 0 follows PPU A10 when control bit 5 is 1. When control bit 5 is 0, output bit 0 is the register's bit 0.
- R5: In mode 0, a name-table fetch takes output bits 7:1 from register 6 or register 7. With control bit 2 = 0, A11 chooses between them; with control bit 2 = 1, A10 chooses (0 picks register 6). With control bit 5 = 0, output bit 0 is that register's bit 0.
- R6: In mode 0 with control bit 5 = 1, name-table output bit 0 is set by control bits 3:2. The values are: 0 gives A10, 1 gives A11, 2 gives 0, 3 gives 1.
- R7: In mode 1, a name-table fetch outputs register 4 + q unchanged. Control bits 2, 3 and 5 have no effect on it.
- R8: In mode 2, a name-table fetch outputs register 6 or register 7 unchanged. With control bit 2 = 0, A10 chooses between them; with control bit 2 = 1, A11 chooses. Control bits 3 and 5 have no effect on it.
- R9: Mode 3 name-table fetches follow R8 when control bit 5 = 0. When control bit 5 = 1, output bit 0 is set by control bits 3:2. The values are: 0 gives A11, 1 gives A10, 2 gives 1, 3 gives 0.
- R10: The internal-RAM select is 1 exactly when A13 = 1 and control bit 4 = 0.
- R11: During a name-table fetch, the internal-RAM A10 output equals CHR output bit 0, whatever the state of control bit 4.
- R12: Control bits 7:6 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ppu_a_hi | input | 4 | PPU address lines A13..A10 |
| ctl_byte | input | 8 | Banking-style control byte |
| bank_flat | input | NUM_BANKS*BANK_W | Eight bank registers, register k at bits k*BANK_W +: BANK_W |
| chr_addr | output | BANK_W | CHR memory address lines A17..A10 |
| nt_int_sel | output | 1 | Routes the name-table fetch to the internal RAM |
| nt_int_a10 | output | 1 | A10 line of the internal RAM |

## Verification
An exhaustive sweep crosses every value of control bits 5:0 with all sixteen
A13..A10 codes. The bank values in this sweep have distinct upper bits and mixed
least significant bits. This exposes a wrong register choice, a wrong selector
line, a swapped or inverted mirroring table, and a 2 KiB slice that keeps the
register's LSB where it should take PPU A10, or the reverse.

A second pass sets control bits 7:6 and must reproduce the same mapping.
Random bank contents and random control bytes then check that no case depends
on particular register values.

// File: rtl/chr_bank_mapper_pkg.sv
package chr_bank_mapper_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT    = 2'd0,
    MODE_WIDE_PAT  = 2'd1,
    MODE_SPLIT     = 2'd2,
    MODE_SPLIT_FIX = 2'd3
  } bank_mode_e;

  // Control byte layout, LSB field last.
  typedef struct packed {
    logic       ram_en;    // bit 7, not used here
    logic       spare;     // bit 6, not used here
    logic       a10_rule;  // bit 5
    logic       nt_src;    // bit 4: 1 = CHR memory, 0 = internal RAM
    logic [1:0] mir;       // bits 3:2
    bank_mode_e mode;      // bits 1:0
  } ctl_t;

  localparam int unsigned NUM_BANK_REGS = 8;

endpackage

// File: rtl/chr_pattern_map.sv
module chr_pattern_map
  import chr_bank_mapper_pkg::*;
#(
  parameter int unsigned BANK_W = 8
) (
  input  ctl_t              ctl,
  input  logic [2:0]        slot,
  input  logic [BANK_W-1:0] banks [NUM_BANK_REGS],
  output logic [BANK_W-1:0] pat_addr
);

  logic [BANK_W-1:0] wide_reg;
  logic              wide_lsb;

  always_comb begin
    wide_reg = '0;
    wide_lsb = 1'b0;
    pat_addr = '0;
    case (ctl.mode)
      MODE_DIRECT: pat_addr = banks[slot];
      MODE_WIDE_PAT: begin
        wide_reg = banks[{1'b0, slot[2:1]}];
        wide_lsb = ctl.a10_rule ? slot[0] : wide_reg[0];
        pat_addr = {wide_reg[BANK_W-1:1], wide_lsb};
      end
      default: begin
        if (!slot[2]) begin
          pat_addr = banks[slot];
        end else begin
          wide_reg = banks[{2'b10, slot[1]}];
          wide_lsb = ctl.a10_rule ? slot[0] : wide_reg[0];
          pat_addr = {wide_reg[BANK_W-1:1], wide_lsb};
        end
      end
    endcase
  end

endmodule

// File: rtl/chr_ntable_map.sv
module chr_ntable_map
  import chr_bank_mapper_pkg::*;
#(
  parameter int unsigned BANK_W = 8
) (
  input  ctl_t              ctl,
  input  logic [1:0]        q,       // {A11, A10}
  input  logic [BANK_W-1:0] banks [NUM_BANK_REGS],
  output logic [BANK_W-1:0] nt_addr,
  output logic              nt_a10
);

  logic              pick_hi;
  logic [BANK_W-1:0] src;
  logic              lsb;

  always_comb begin
    pick_hi = 1'b0;
    src     = banks[6];
    lsb     = 1'b0;
    case (ctl.mode)
      MODE_DIRECT: begin
        pick_hi = ctl.mir[0] ? q[0] : q[1];
        src     = pick_hi ? banks[7] : banks[6];
        if (ctl.a10_rule) begin
          case (ctl.mir)
            2'd0:    lsb = q[0];
            2'd1:    lsb = q[1];
            2'd2:    lsb = 1'b0;
            default: lsb = 1'b1;
          endcase
        end else begin
          lsb = src[0];
        end
      end
      MODE_WIDE_PAT: begin
        src = banks[{1'b1, q}];
        lsb = src[0];
      end
      default: begin
        pick_hi = ctl.mir[0] ? q[1] : q[0];
        src     = pick_hi ? banks[7] : banks[6];
        if (ctl.mode == MODE_SPLIT_FIX && ctl.a10_rule) begin
          case (ctl.mir)
            2'd0:    lsb = q[1];
            2'd1:    lsb = q[0];
            2'd2:    lsb = 1'b1;
            default: lsb = 1'b0;
          endcase
        end else begin
          lsb = src[0];
        end
      end
    endcase
    nt_addr = {src[BANK_W-1:1], lsb};
    nt_a10  = lsb;
  end

endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
  import chr_bank_mapper_pkg::*;
#(
  parameter int unsigned BANK_W = 8,
  localparam int unsigned NUM_BANKS = NUM_BANK_REGS,
  localparam int unsigned FLAT_W = NUM_BANKS * BANK_W
) (
  input  logic [3:0]        ppu_a_hi,
  input  logic [7:0]        ctl_byte,
  input  logic [FLAT_W-1:0] bank_flat,
  output logic [BANK_W-1:0] chr_addr,
  output logic              nt_int_sel,
  output logic              nt_int_a10
);

  ctl_t              ctl;
  logic [BANK_W-1:0] banks [NUM_BANKS];
  logic [BANK_W-1:0] pat_addr;
  logic [BANK_W-1:0] nt_addr;
  logic              nt_a10;
  logic              nt_fetch;

  assign ctl      = ctl_t'(ctl_byte);
  assign nt_fetch = ppu_a_hi[3];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_unpack
    assign banks[g] = bank_flat[g*BANK_W +: BANK_W];
  end

  chr_pattern_map #(.BANK_W(BANK_W)) u_pat (
    .ctl      (ctl),
    .slot     (ppu_a_hi[2:0]),
    .banks    (banks),
    .pat_addr (pat_addr)
  );

  chr_ntable_map #(.BANK_W(BANK_W)) u_nt (
    .ctl     (ctl),
    .q       (ppu_a_hi[1:0]),
    .banks   (banks),
    .nt_addr (nt_addr),
    .nt_a10  (nt_a10)
  );

  assign chr_addr   = nt_fetch ? nt_addr : pat_addr;
  assign nt_int_sel = nt_fetch & ~ctl.nt_src;
  assign nt_int_a10 = nt_a10;

endmodule

// File: rtl/chr_bank_mapper_chk.sv
module chr_bank_mapper_chk #(
  parameter int unsigned BANK_W = 8
) (
  input logic [3:0]          ppu_a_hi,
  input logic [7:0]          ctl_byte,
  input logic [8*BANK_W-1:0] bank_flat,
  input logic [BANK_W-1:0]   chr_addr,
  input logic                nt_int_sel,
  input logic                nt_int_a10
);

  logic [BANK_W-1:0] reg_slot;
  logic [BANK_W-1:0] reg_nt1;

  assign reg_slot = bank_flat[ppu_a_hi[2:0]*BANK_W +: BANK_W];
  assign reg_nt1  = bank_flat[(4 + ppu_a_hi[1:0])*BANK_W +: BANK_W];

  always_comb begin
    if (!ppu_a_hi[3]) begin
      p_no_int_sel_pattern_r10: assert (!nt_int_sel);
    end
    if (ppu_a_hi[3] && !ctl_byte[4]) begin
      p_int_sel_nametable_r10: assert (nt_int_sel);
    end
    if (ppu_a_hi[3]) begin
      p_int_a10_tracks_chr_r11: assert (nt_int_a10 == chr_addr[0]);
    end
    if (!ppu_a_hi[3] && ctl_byte[1:0] == 2'd0) begin
      p_direct_pattern_r1: assert (chr_addr == reg_slot);
    end
    if (ppu_a_hi[3] && ctl_byte[1:0] == 2'd1) begin
      p_wide_nametable_r7: assert (chr_addr == reg_nt1);
    end
    if (!ppu_a_hi[3] && ctl_byte[1:0] == 2'd1 && ctl_byte[5]) begin
      p_wide_slice_a10_r4: assert (chr_addr[0] == ppu_a_hi[0]);
    end
  end

endmodule

bind chr_bank_mapper chr_bank_mapper_chk #(.BANK_W(BANK_W)) u_chk (
  .ppu_a_hi   (ppu_a_hi),
  .ctl_byte   (ctl_byte),
  .bank_flat  (bank_flat),
  .chr_addr   (chr_addr),
  .nt_int_sel (nt_int_sel),
  .nt_int_a10 (nt_int_a10)
);

// File: tb/chr_bank_mapper_tb.sv
module chr_bank_mapper_tb;

  localparam int W = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    ppu_a_hi = '0;
  logic [7:0]    ctl_byte = '0;
  logic [8*W-1:0] bank_flat = '0;
  logic [W-1:0]  chr_addr;
  logic          nt_int_sel;
  logic          nt_int_a10;

  int n_cmp = 0;
  int n_bad = 0;
  int bank_v [8];

  always #2 clk = ~clk;

  chr_bank_mapper #(.BANK_W(W)) u_dut (
    .ppu_a_hi   (ppu_a_hi),
    .ctl_byte   (ctl_byte),
    .bank_flat  (bank_flat),
    .chr_addr   (chr_addr),
    .nt_int_sel (nt_int_sel),
    .nt_int_a10 (nt_int_a10)
  );

  // Behavioural reference: returns expected chr address, sets tag.
  function automatic int ref_addr(input int a, input int c, output string tag);
    int a10 = a & 1, a11 = (a >> 1) & 1, a12 = (a >> 2) & 1, a13 = (a >> 3) & 1;
    int mode = c & 3, mir = (c >> 2) & 3, rule = (c >> 5) & 1;
    int r, lsb, which;
    if (a13 == 0) begin
      if (mode == 0) begin
        tag = "R1"; return bank_v[a & 7];
      end
      if (mode == 1) begin
        r = bank_v[(a >> 1) & 3];
        tag = rule ? "R4" : "R2";
        return (r & 'hFE) | (rule ? a10 : (r & 1));
      end
      if (a12 == 0) begin
        tag = "R3"; return bank_v[a & 3];
      end
      r = bank_v[4 + a11];
      tag = rule ? "R4" : "R3";
      return (r & 'hFE) | (rule ? a10 : (r & 1));
    end
    if (mode == 1) begin
      tag = "R7"; return bank_v[4 + (a & 3)];
    end
    if (mode == 0) begin
      which = (mir & 1) ? a10 : a11;
      r = which ? bank_v[7] : bank_v[6];
      if (!rule) begin tag = "R5"; return r; end
      tag = "R6";
      lsb = (mir == 0) ? a10 : (mir == 1) ? a11 : (mir == 2) ? 0 : 1;
      return (r & 'hFE) | lsb;
    end
    which = (mir & 1) ? a11 : a10;
    r = which ? bank_v[7] : bank_v[6];
    if (mode == 2) begin tag = "R8"; return r; end
    if (!rule) begin tag = "R9"; return r; end
    tag = "R9";
    lsb = (mir == 0) ? a11 : (mir == 1) ? a10 : (mir == 2) ? 1 : 0;
    return (r & 'hFE) | lsb;
  endfunction

  task automatic load_banks();
    for (int i = 0; i < 8; i++) bank_flat[i*W +: W] = bank_v[i][W-1:0];
  endtask

  task automatic apply(input int a, input int c, input string force_tag);
    string tag;
    int exp_a, exp_sel;
    @(negedge clk);
    ppu_a_hi = a[3:0];
    ctl_byte = c[7:0];
    load_banks();
    @(posedge clk);
    #1;
    exp_a   = ref_addr(a, c, tag);
    exp_sel = ((a >> 3) & 1) && !((c >> 4) & 1);
    if (force_tag != "") tag = force_tag;
    n_cmp++;
    if (int'(chr_addr) != exp_a) begin
      n_bad++;
      $display("FAIL %s chr_addr a=%0h c=%02h act=%02h exp=%02h", tag, a, c, chr_addr, exp_a);
    end
    n_cmp++;
    if (int'(nt_int_sel) != exp_sel) begin
      n_bad++;
      $display("FAIL R10 nt_int_sel a=%0h c=%02h act=%0d exp=%0d", a, c, nt_int_sel, exp_sel);
    end
    if (a >= 8) begin
      n_cmp++;
      if (int'(nt_int_a10) != (exp_a & 1)) begin
        n_bad++;
        $display("FAIL R11 nt_int_a10 a=%0h c=%02h act=%0d exp=%0d", a, c, nt_int_a10, exp_a & 1);
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < 8; i++) bank_v[i] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset state: all-zero inputs map to register 0 (zero), no RAM select.
    apply(0, 0, "R1");
    // Distinct upper bits, mixed LSBs.
    for (int i = 0; i < 8; i++) bank_v[i] = (i * 'h22 + 'h10 + ((i * 5) & 1)) & 'hFF;
    for (int c = 0; c < 64; c++)
      for (int a = 0; a < 16; a++) apply(a, c, "");
    // R12: bits 7:6 set must not change anything.
    for (int c = 0; c < 64; c++)
      for (int a = 0; a < 16; a++) apply(a, c | ((1 + (a % 3)) << 6), "R12");
    // Random banks and controls.
    for (int k = 0; k < 3000; k++) begin
      for (int i = 0; i < 8; i++) bank_v[i] = int'($urandom_range(0, 255));
      apply(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)), "");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule